// File: doc/BRIEF.md
# Shutdown and Power-Up Output Sequencer

This block sits between a clock-synthesis loop and its output pins. It holds a bank of six clock outputs and one reference relay output low whenever the loop cannot be trusted. That covers power-on, the time the active-low sleep input is driven low, and a settling window after either event ends. While sleep is active it also asks the loop to power down. When the settling window ends, it first raises the oscillator enable and then, one cycle later, opens the output gates.

All timing comes from a free-running local timing clock. The settling window is a parameter counted in cycles of that clock. One timer serves both power-on and the release of sleep. Sleep and reset are asynchronous inputs and are brought into the clock domain by synchronizers. A two-bit status port shows whether the block is held off, settling or running.

Top module: `pwr_out_sequencer`

## Requirements
- R1: While the power-on reset is asserted, status is 0 (held off), the loop power-down request is high, and the oscillator enable, the output enable and every gated output are low.
- R2: After the power-on reset is released with sleep high, status stays 0 through the fourth clock edge. It reads 1 (settling) for exactly HOLD_CYCLES cycles. It then reads 2 (running) with the oscillator enable high.
- R3: When sleep goes low, the third clock edge afterwards sets status to 0, raises the loop power-down request, and drops the oscillator enable and the output enable. All of these hold while sleep stays low.
- R4: When sleep goes high again, status becomes 1 on the third edge and stays 1 for exactly HOLD_CYCLES cycles before it changes to 2. This is the same window that power-on uses.
- R5: If sleep goes low during the settling window, the window is abandoned. The next release counts a full HOLD_CYCLES again from zero.
- R6: Each of the six gated clock outputs and the gated reference output equals its input when the output enable is high and is 0 when it is low.
- R7: The status codes are 0 for held off, 1 for settling and 2 for running. The loop power-down request is high exactly when status is 0.
- R8: The output enable is a register. It rises only one cycle after the oscillator enable has risen, and it is never high while the oscillator enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running local timing clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous assert |
| sleep_n_i | input | 1 | Shutdown request, active low, asynchronous |
| clk_bank_i | input | NUM_CLK (6) | Ungated synthesized clock bank |
| ref_i | input | 1 | Ungated reference relay signal |
| clk_bank_o | output | NUM_CLK (6) | Gated clock bank, forced low when disabled |
| ref_o | output | 1 | Gated reference relay, forced low when disabled |
| osc_en_o | output | 1 | Oscillator enable |
| loop_pd_o | output | 1 | Loop power-down request |
| out_en_o | output | 1 | Registered output-gate enable |
| status_o | output | 2 | 0 held off, 1 settling, 2 running |

## Verification
Every result has a fixed latency from the edge at which a driver changes an input. A sleep change passes two synchronizer stages and then the state register, so it shows on the third edge. A reset release adds two more stages. The running state follows HOLD_CYCLES edges after settling begins, and the output enable follows one edge later. The driver tasks turn each stimulus into expected items tagged with the exact cycle numbers. The monitor compares them at the falling edge of that cycle, so every sample is taken half a period after the edge that produced it.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
  typedef enum logic [1:0] {
    PH_OFF    = 2'd0,
    PH_SETTLE = 2'd1,
    PH_RUN    = 2'd2
  } phase_e;
endpackage

// File: rtl/sqr_sync.sv
module sqr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/sqr_hold_timer.sv
module sqr_hold_timer #(
  parameter int HOLD_CYCLES = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = run && (cnt_q != LAST);
    if (!run)        cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == LAST);

  // R5: an idle timer always restarts from zero
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
  // R2: done may only appear after counting has stepped through the window
  p_done_after_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(run));
endmodule

// File: rtl/sqr_out_gate.sv
module sqr_out_gate #(
  parameter int NUM_CLK = 6
) (
  input  logic               en,
  input  logic [NUM_CLK-1:0] bank_i,
  input  logic               ref_i,
  output logic [NUM_CLK-1:0] bank_o,
  output logic               ref_o
);
  for (genvar g = 0; g < NUM_CLK; g++) begin : g_lane
    assign bank_o[g] = bank_i[g] & en;
  end
  assign ref_o = ref_i & en;

  // R6: disabled lanes are quiet
  always_comb begin
    p_quiet_lanes_r6: assert (en || (bank_o == '0 && !ref_o));
  end
endmodule

// File: rtl/pwr_out_sequencer.sv
module pwr_out_sequencer
  import sqr_pkg::*;
#(
  parameter int NUM_CLK     = 6,
  parameter int HOLD_CYCLES = 8192,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               por_n_i,
  input  logic               sleep_n_i,
  input  logic [NUM_CLK-1:0] clk_bank_i,
  input  logic               ref_i,
  output logic [NUM_CLK-1:0] clk_bank_o,
  output logic               ref_o,
  output logic               osc_en_o,
  output logic               loop_pd_o,
  output logic               out_en_o,
  output logic [1:0]         status_o
);
  logic   rst_n;
  logic   awake;
  logic   tmr_done;
  logic   tmr_run;
  phase_e state_q;
  phase_e state_d;
  logic   out_en_q;
  logic   out_en_d;

  sqr_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk_i), .arst_n(por_n_i), .d(1'b1), .q(rst_n)
  );

  sqr_sync #(.STAGES(SYNC_STAGES)) u_sleep_sync (
    .clk(clk_i), .arst_n(rst_n), .d(sleep_n_i), .q(awake)
  );

  assign tmr_run = (state_q == PH_SETTLE);

  sqr_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk(clk_i), .rst_n(rst_n), .run(tmr_run), .done(tmr_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      PH_OFF:    if (awake) state_d = PH_SETTLE;
      PH_SETTLE: if (!awake) state_d = PH_OFF;
                 else if (tmr_done) state_d = PH_RUN;
      PH_RUN:    if (!awake) state_d = PH_OFF;
      default:   state_d = PH_OFF;
    endcase
    out_en_d = (state_q == PH_RUN) && (state_d == PH_RUN);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PH_OFF;
      out_en_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      out_en_q <= out_en_d;
    end
  end

  assign osc_en_o  = (state_q == PH_RUN);
  assign loop_pd_o = (state_q == PH_OFF);
  assign out_en_o  = out_en_q;
  assign status_o  = state_q;

  sqr_out_gate #(.NUM_CLK(NUM_CLK)) u_gate (
    .en(out_en_q), .bank_i(clk_bank_i), .ref_i(ref_i),
    .bank_o(clk_bank_o), .ref_o(ref_o)
  );

  // R8: gates open only behind a running oscillator
  p_en_needs_osc_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    out_en_q |-> osc_en_o);
  // R8: output enable rises one cycle after the oscillator enable
  p_en_rise_late_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(out_en_q) |-> $past(osc_en_o));
  // R2: running is entered only when the timer reports the window complete
  p_run_after_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == PH_RUN && $past(state_q) == PH_SETTLE) |-> $past(tmr_done));
  // R4: settling starts only from a synchronized release
  p_settle_on_wake_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == PH_SETTLE && $past(state_q) == PH_OFF) |-> $past(awake));
  // R3: a synchronized sleep forces held-off on the next edge
  p_sleep_forces_off_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !awake |=> (state_q == PH_OFF && !out_en_q));
endmodule

// File: tb/pwr_out_sequencer_test.sv
module pwr_out_sequencer_test;
  localparam int NUM_CLK = 6;
  localparam int HOLD    = 16;

  logic               clk = 1'b0;
  logic               por_n;
  logic               sleep_n;
  logic [NUM_CLK-1:0] bank_i;
  logic               ref_in;
  logic [NUM_CLK-1:0] bank_o;
  logic               ref_out;
  logic               osc_en;
  logic               loop_pd;
  logic               out_en;
  logic [1:0]         status;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  typedef struct {
    int         cyc;
    logic [1:0] st;
    logic       osc;
    logic       en;
    logic       pd;
    string      req;
  } exp_t;

  exp_t sb[$];
  exp_t it;

  pwr_out_sequencer #(.NUM_CLK(NUM_CLK), .HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .por_n_i(por_n), .sleep_n_i(sleep_n),
    .clk_bank_i(bank_i), .ref_i(ref_in),
    .clk_bank_o(bank_o), .ref_o(ref_out),
    .osc_en_o(osc_en), .loop_pd_o(loop_pd), .out_en_o(out_en), .status_o(status)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int c, input logic [1:0] st, input logic osc,
                      input logic en, input string req);
    exp_t e;
    e.cyc = c; e.st = st; e.osc = osc; e.en = en; e.pd = (st == 2'd0); e.req = req;
    sb.push_back(e);
  endtask

  // release seen at cycle n; base = edges until the state register still reads held-off
  task automatic expect_release(input int n, input int base, input string req);
    push(n + base,            2'd0, 1'b0, 1'b0, req);
    push(n + base + 1,        2'd1, 1'b0, 1'b0, req);
    push(n + base + HOLD,     2'd1, 1'b0, 1'b0, req);
    push(n + base + 1 + HOLD, 2'd2, 1'b1, 1'b0, {req, "/R8"});
    push(n + base + 2 + HOLD, 2'd2, 1'b1, 1'b1, {req, "/R6"});
  endtask

  task automatic fail_line(input string req, input string what, input int act, input int exp_v);
    errors++;
    $display("FAIL %s cycle %0d %s: actual %0h expected %0h", req, cyc, what, act, exp_v);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      it = sb.pop_front();
      checks++;
      if (it.cyc != cyc)         fail_line(it.req, "missed slot", cyc, it.cyc);
      else if (status !== it.st) fail_line({it.req, "/R7"}, "status", int'(status), int'(it.st));
      else if (osc_en !== it.osc) fail_line(it.req, "osc_en", int'(osc_en), int'(it.osc));
      else if (out_en !== it.en) fail_line(it.req, "out_en", int'(out_en), int'(it.en));
      else if (loop_pd !== it.pd) fail_line({it.req, "/R7"}, "loop_pd", int'(loop_pd), int'(it.pd));
      else if (bank_o !== (it.en ? bank_i : '0))
        fail_line({it.req, "/R6"}, "clk bank", int'(bank_o), int'(it.en ? bank_i : '0));
      else if (ref_out !== (it.en & ref_in))
        fail_line({it.req, "/R6"}, "ref", int'(ref_out), int'(it.en & ref_in));
    end
  end

  initial begin
    int n;
    por_n = 1'b0; sleep_n = 1'b1; bank_i = 6'b101101; ref_in = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    push(cyc + 1, 2'd0, 1'b0, 1'b0, "R1");
    push(cyc + 2, 2'd0, 1'b0, 1'b0, "R1");
    repeat (3) @(negedge clk);
    n = cyc; por_n = 1'b1;
    expect_release(n, 4, "R2");
    repeat (HOLD + 12) @(negedge clk);

    // R6: another bank pattern while running
    bank_i = 6'b010011; ref_in = 1'b0;
    push(cyc + 1, 2'd2, 1'b1, 1'b1, "R6");
    repeat (3) @(negedge clk);
    ref_in = 1'b1;
    push(cyc + 1, 2'd2, 1'b1, 1'b1, "R6");
    repeat (2) @(negedge clk);

    // R3: shutdown
    n = cyc; sleep_n = 1'b0;
    push(n + 2, 2'd2, 1'b1, 1'b1, "R3");
    push(n + 3, 2'd0, 1'b0, 1'b0, "R3");
    push(n + 9, 2'd0, 1'b0, 1'b0, "R3");
    repeat (10) @(negedge clk);

    // R4: release restarts the same window
    n = cyc; sleep_n = 1'b1;
    expect_release(n, 2, "R4");
    repeat (HOLD + 10) @(negedge clk);

    // R5: abort during settling, then full window again
    n = cyc; sleep_n = 1'b0;
    push(n + 3, 2'd0, 1'b0, 1'b0, "R5");
    repeat (8) @(negedge clk);
    n = cyc; sleep_n = 1'b1;
    push(n + 3, 2'd1, 1'b0, 1'b0, "R5");
    repeat (8) @(negedge clk);
    n = cyc; sleep_n = 1'b0;
    push(n + 2, 2'd1, 1'b0, 1'b0, "R5");
    push(n + 3, 2'd0, 1'b0, 1'b0, "R5");
    repeat (6) @(negedge clk);
    n = cyc; sleep_n = 1'b1;
    expect_release(n, 2, "R5");
    repeat (HOLD + 10) @(negedge clk);

    wait (sb.size() == 0);
    @(negedge clk);
    done_run = 1'b1;
  end

  initial begin
    int w;
    w = 0;
    while (!done_run && w < 20000) begin
      @(posedge clk);
      w++;
    end
    if (!done_run) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule